// File: doc/BRIEF.md
# Stored-Pattern Scan Chain Initializer

This block puts a design into one fixed functional starting state by filling its internal scan chains from a constant pattern held on chip. The tester needs no scan data for this. It raises a single enable input and then applies shift clocks. While the enable is high, a per-chain multiplexer takes each chain's scan-in bit from the stored pattern and not from the test decompressor.

A modulo-L address counter picks one M-bit pattern word on every shift clock, so every chain receives its next bit at the same time. After exactly L shift cycles every chain holds its share of the pattern, and the block raises a done flag. When the enable is low the decompressor passes straight through and the counter is held at zero. The pattern is a build-time parameter, so only one initialization state can be produced.

Control is a three-state machine:
- IDLE: the enable is low and the decompressor is routed to the chains.
- LOAD: pattern words are being streamed into the chains.
- DONE: the final word has been shifted.

The transitions are:
- IDLE→LOAD: the enable is high and the current word is not the last one.
- IDLE→DONE: the enable is high and the pattern is a single word.
- LOAD→DONE: the enable is high and the last word is being presented.
- LOAD→IDLE and DONE→IDLE: the enable is sampled low.

Top module: `scan_pattern_loader`

## Requirements
- R1: After reset, `init_done` is 0, and with `init_en` low `chain_si` equals `decomp_bits`.
- R2: While `init_en` is 0, `chain_si` equals `decomp_bits` bit for bit, and `init_done` is 0 from the next clock edge on.
- R3: While `init_en` is 1, `chain_si` equals the stored word at the current address. Word i occupies bits [i*M +: M] of `PATTERN`, and bit j of that word drives chain j.
- R4: In the first cycle with `init_en` high, word 0 is presented combinationally.
- R5: Each rising clock edge with `init_en` high advances the address by one. From L-1 the address wraps to 0, so the pattern repeats if shifting continues.
- R6: Each rising edge with `init_en` low clears the address to 0. An enable that is dropped in the middle of a load and raised again restarts at word 0.
- R7: `init_done` stays low for the first L-1 edges of a load and goes high at the L-th edge, which is the edge that shifts word L-1.
- R8: `init_done` stays high while `init_en` stays high, including after the address wraps, and falls at the first edge with `init_en` low.
- R9: While `init_en` is 1, the value of `decomp_bits` has no effect on `chain_si`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock for the scan chains and the address counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en | input | 1 | Tester-driven pin that selects the stored pattern |
| decomp_bits | input | M | Per-chain output of the test decompressor |
| chain_si | output | M | Scan-in bit for each internal chain |
| init_done | output | 1 | High once all L words have been shifted |

## Verification
The bench aims at the cycle in which the enable rises. A design that registered the ROM read would present word 0 one cycle late and shift every chain out of alignment. It also checks the edge on which `init_done` rises: a design that compared against L rather than L-1 would raise the flag one cycle late or never. Aborted loads that are then restarted catch a counter that fails to clear. Runs that continue past L catch a missing wrap or a done flag that drops at the wrap. Random decompressor values are applied during loads, so a multiplexer with an inverted or missing select shows up as wrong chain bits.

// File: rtl/scan_loader_pkg.sv
package scan_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } load_state_t;

    function automatic int addr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/pattern_addr_counter.sv
module pattern_addr_counter #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = scan_loader_pkg::addr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    assign last = (addr == LAST_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (advance) begin
            addr <= last ? '0 : addr + 1'b1;
        end
    end

    // R5: step by one, wrapping after the final word
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (addr == (($past(addr) == LAST_ADDR) ? '0 : $past(addr) + 1'b1)));

    // R6: a low enable returns the address to zero
    assert_addr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (addr == '0));

    // R5: the address never leaves the pattern range
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST_ADDR);

endmodule

// File: rtl/pattern_rom.sv
module pattern_rom #(
    parameter int                        DEPTH   = 16,
    parameter int                        WIDTH   = 8,
    parameter logic [DEPTH*WIDTH-1:0]    PATTERN = '0,
    parameter int                        ADDR_W  = scan_loader_pkg::addr_width(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  word
);
    logic [WIDTH-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = PATTERN[i*WIDTH +: WIDTH];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) word = words[i];
        end
    end

endmodule

// File: rtl/chain_select.sv
module chain_select #(
    parameter int CHAINS = 8
) (
    input  logic              use_rom,
    input  logic [CHAINS-1:0] rom_bits,
    input  logic [CHAINS-1:0] comp_bits,
    output logic [CHAINS-1:0] si_bits
);
    for (genvar j = 0; j < CHAINS; j++) begin : g_chain
        assign si_bits[j] = use_rom ? rom_bits[j] : comp_bits[j];
    end

endmodule

// File: rtl/load_ctrl_fsm.sv
module load_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic last_word,
    output logic clear_addr,
    output logic advance_addr,
    output logic select_rom,
    output logic done
);
    import scan_loader_pkg::*;

    load_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = last_word ? ST_DONE : ST_LOAD;
            ST_LOAD: begin
                if (!enable)        state_d = ST_IDLE;
                else if (last_word) state_d = ST_DONE;
            end
            ST_DONE: if (!enable) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clear_addr   = !enable;
        advance_addr = enable;
        select_rom   = enable;
        done         = (state_q == ST_DONE);
    end

    // R7: done only rises on the edge that shifted the final word
    assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(enable && last_word));

    // R8: done holds while the enable holds
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable) |=> done);

    // R2: a low enable drops done at the next edge
    assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done);

endmodule

// File: rtl/scan_pattern_loader.sv
module scan_pattern_loader #(
    parameter int                          CHAINS    = 8,
    parameter int                          CHAIN_LEN = 16,
    parameter logic [CHAIN_LEN*CHAINS-1:0] PATTERN   = '0
) (
    input  logic              shift_clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic [CHAINS-1:0] decomp_bits,
    output logic [CHAINS-1:0] chain_si,
    output logic              init_done
);
    localparam int ADDR_W = scan_loader_pkg::addr_width(CHAIN_LEN);

    logic [ADDR_W-1:0] rom_addr;
    logic [CHAINS-1:0] rom_word;
    logic              last_word, clear_addr, advance_addr, select_rom;

    load_ctrl_fsm u_ctrl (
        .clk          (shift_clk),
        .rst_n        (rst_n),
        .enable       (init_en),
        .last_word    (last_word),
        .clear_addr   (clear_addr),
        .advance_addr (advance_addr),
        .select_rom   (select_rom),
        .done         (init_done)
    );

    pattern_addr_counter #(.DEPTH(CHAIN_LEN), .ADDR_W(ADDR_W)) u_addr (
        .clk     (shift_clk),
        .rst_n   (rst_n),
        .clear   (clear_addr),
        .advance (advance_addr),
        .addr    (rom_addr),
        .last    (last_word)
    );

    pattern_rom #(
        .DEPTH(CHAIN_LEN), .WIDTH(CHAINS), .PATTERN(PATTERN), .ADDR_W(ADDR_W)
    ) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    chain_select #(.CHAINS(CHAINS)) u_mux (
        .use_rom   (select_rom),
        .rom_bits  (rom_word),
        .comp_bits (decomp_bits),
        .si_bits   (chain_si)
    );

    // R4: the cycle after a low enable always shows word 0 if enabled
    assert_first_word_R4: assert property (@(posedge shift_clk) disable iff (!rst_n)
        !init_en |=> (init_en -> (chain_si == PATTERN[CHAINS-1:0])));

endmodule

// File: tb/scan_pattern_loader_tb_top.sv
module scan_pattern_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M = 8;
    localparam int L = 16;
    localparam logic [L*M-1:0] PAT = 128'hF00D_1234_5678_9ABC_DEF0_0FF0_A55A_3C3C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [M-1:0] dec = '0;
    logic [M-1:0] si;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cnt_m = 0;
    bit done_m = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_pattern_loader #(.CHAINS(M), .CHAIN_LEN(L), .PATTERN(PAT)) dut_i (
        .shift_clk(clk), .rst_n(rst_n), .init_en(en),
        .decomp_bits(dec), .chain_si(si), .init_done(done)
    );

    function automatic logic [M-1:0] exp_word(input int i);
        return PAT[i*M +: M];
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, check mid-low phase, then take the posedge and update model
    task automatic step(input bit en_v, input logic [M-1:0] dec_v, input string req);
        @(negedge clk);
        en = en_v;
        dec = dec_v;
        #1;
        check({req, " data"}, si, en_v ? exp_word(cnt_m) : dec_v);
        check({req, " done"}, {7'd0, done}, {7'd0, done_m});
        @(posedge clk);
        if (!en_v) begin
            cnt_m = 0;
            done_m = 1'b0;
        end else begin
            if (cnt_m == L - 1) done_m = 1'b1;
            cnt_m = (cnt_m + 1) % L;
        end
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1 reset state
        dec = 8'h5A;
        #1;
        check("R1 reset done", {7'd0, done}, 8'd0);
        check("R1 reset data", si, 8'h5A);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R2 pass-through
        for (int i = 0; i < 4; i++) step(1'b0, M'($urandom), "R2");
        // R4 R3 R5 R7 full load with random decomp (R9), then wrap (R8)
        for (int i = 0; i < L; i++) step(1'b1, M'($urandom), "R3 R4 R9 R7");
        for (int i = 0; i < 5; i++) step(1'b1, M'($urandom), "R5 R8 wrap");
        step(1'b0, 8'hC3, "R8 fall");
        step(1'b0, 8'h3C, "R2 done low");
        // R6 aborted load then restart
        for (int i = 0; i < 7; i++) step(1'b1, 8'hFF, "R6 partial");
        step(1'b0, 8'h00, "R6 abort");
        for (int i = 0; i < L + 2; i++) step(1'b1, 8'h00, "R6 restart R7");
        // R9 extreme decomp values under load
        step(1'b0, 8'h81, "R2");
        for (int i = 0; i < L; i++) step(1'b1, (i % 2) ? 8'hFF : 8'h00, "R9");
        // random mix
        for (int i = 0; i < 600; i++) step(($urandom % 5) != 0, M'($urandom), "R3 R5 R6 R7 R8 random");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule